// File: doc/BRIEF.md
# Dual-Context Frame Register Switch

This block keeps two complete shadow copies, context A and context B, of the per-frame control values that an image-readout timing engine consumes. Examples are integration time, line length, frame length, window start and end columns and rows, binning factors, and per-channel and global gains. A host may rewrite either copy at any moment through a single-cycle write port. A one-bit context select chooses which copy the timing engine is to use.

Nothing the host does reaches the timing engine directly. The active values are reloaded only at accepted frame boundaries. A boundary is a frame-start pulse that arrives while the readout-active flag is low. When the select changes, the integration time moves to the new context at the first boundary that sees the new select value. Every other field moves one boundary later. This lets the exposure of the frame being integrated match the settings used to read it out.

Field 0 of the output vector is always the integration time. The remaining field indices are free for the integrating chip to assign. A typical assignment is line length, frame length, column start, column end, row start, row end, row binning, column binning, four colour gains, a global gain and an analog gain.

Top module: `ctx_bank_switch`

## Requirements
- R1: After reset, both shadow copies and the active outputs hold the per-field defaults given by `DEF_VALS`. Field i sits at bits [i*DATA_W +: DATA_W] of both `DEF_VALS` and `act_regs`. Context A is active for every field, so `integ_ctx_o` and `rest_ctx_o` are 0. The encoding is 0 for A and 1 for B.
- R2: `act_regs`, `integ_ctx_o` and `rest_ctx_o` change only on a clock edge where an accepted boundary occurs, that is, where `frame_start` is 1 and `readout_active` is 0.
- R3: At an accepted boundary, field 0 (integration time) is loaded from the context named by `ctx_sel` in that cycle, and `integ_ctx_o` takes that value.
- R4: At an accepted boundary, fields 1 to NUM_FIELDS-1 are loaded from the context that field 0 used since the previous boundary, and `rest_ctx_o` takes that value. A switch therefore reaches the other fields one boundary after it reaches the integration time.
- R5: A switch from B back to A has the same one-boundary and two-boundary latencies as a switch from A to B.
- R6: A write with `wr_en`=1 stores `wr_data` into field `wr_idx` of context `wr_ctx` on that edge, whether or not the context is active or readout is running. Outputs show the value only from the next accepted boundary. A write in the boundary cycle itself is not seen at that boundary; it is seen at the following one.
- R7: A `frame_start` pulse while `readout_active` is 1 is ignored. It reloads no field and moves no context.
- R8: A write whose `wr_idx` is NUM_FIELDS or larger changes no field of either context.
- R9: Only the `ctx_sel` value present in a boundary cycle matters. Toggling it between boundaries and returning it to the old value causes no switch.
- R10: A reversal seen at the boundary where an earlier switch reaches the other fields starts a new sequence from that boundary. The integration time returns at once. The other fields spend one frame on the earlier context and return at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_ctx | input | 1 | Context written: 0 = A, 1 = B |
| wr_idx | input | IDX_W | Field index written |
| wr_data | input | DATA_W | Value written |
| ctx_sel | input | 1 | Requested context: 0 = A, 1 = B |
| frame_start | input | 1 | Frame-start pulse |
| readout_active | input | 1 | High while a frame is being read out |
| act_regs | output | NUM_FIELDS*DATA_W | Active field values; field 0 is integration time |
| integ_ctx_o | output | 1 | Context currently driving field 0 |
| rest_ctx_o | output | 1 | Context currently driving fields 1 and up |

## Verification
The bench builds the block with DATA_W=8 and NUM_FIELDS=5, so IDX_W is 3. With these values, indices 5 to 7 lie outside the field range, which makes the ignored-write case reachable. Five fields also keep field 0 and several lagging fields visible side by side in one output word. Distinct defaults per field (0x11 to 0x55) and distinct written values per context (0xA0+i, 0xB0+i) let every output byte identify both the field and the context it came from. This is what allows the one-boundary and two-boundary latencies, the reversal sequence and the boundary-cycle write to be told apart.

// File: rtl/ctx_bank_switch.sv
module ctx_bank_switch #(
  parameter int DATA_W     = 16,
  parameter int NUM_FIELDS = 15,
  parameter logic [NUM_FIELDS*DATA_W-1:0] DEF_VALS = {
    16'h0010, 16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080,
    16'h0000, 16'h0000, 16'h043F, 16'h0000, 16'h0787, 16'h0000,
    16'h0465, 16'h0898, 16'h0100},
  localparam int IDX_W = $clog2(NUM_FIELDS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_ctx,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         ctx_sel,
  input  logic                         frame_start,
  input  logic                         readout_active,
  output logic [NUM_FIELDS*DATA_W-1:0] act_regs,
  output logic                         integ_ctx_o,
  output logic                         rest_ctx_o
);

  logic boundary;
  logic integ_ctx_q, rest_ctx_q;

  assign boundary    = frame_start & ~readout_active;
  assign integ_ctx_o = integ_ctx_q;
  assign rest_ctx_o  = rest_ctx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_ctx_q <= 1'b0;
      rest_ctx_q  <= 1'b0;
    end else if (boundary) begin
      integ_ctx_q <= ctx_sel;
      rest_ctx_q  <= integ_ctx_q;
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [DATA_W-1:0] DEF = DEF_VALS[g*DATA_W +: DATA_W];
    logic [DATA_W-1:0] sh_a, sh_b, act_q;
    logic hit, pick;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    if (g == 0) begin : g_integ
      assign pick = ctx_sel;
    end else begin : g_rest
      assign pick = integ_ctx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_a  <= DEF;
        sh_b  <= DEF;
        act_q <= DEF;
      end else begin
        if (hit && !wr_ctx) sh_a <= wr_data;
        if (hit &&  wr_ctx) sh_b <= wr_data;
        if (boundary) act_q <= pick ? sh_b : sh_a;
      end
    end

    assign act_regs[g*DATA_W +: DATA_W] = act_q;
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_regs) && $stable(integ_ctx_o) && $stable(rest_ctx_o)); // R2
  AST_IGNORE_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && readout_active) |=> $stable(act_regs) && $stable(integ_ctx_o)); // R7
  AST_INTEG_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> integ_ctx_o == $past(ctx_sel)); // R3
  AST_REST_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> rest_ctx_o == $past(integ_ctx_o)); // R4
  AST_SETTLE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && ctx_sel == integ_ctx_o) |=> rest_ctx_o == integ_ctx_o); // R10

endmodule

// File: tb/ctx_bank_switch_test.sv
`timescale 1ns/1ps
module ctx_bank_switch_test;
  localparam int DW = 8;
  localparam int NF = 5;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_ctx = 0, ctx_sel = 0, frame_start = 0, readout_active = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NF*DW-1:0] act_regs;
  logic integ_ctx_o, rest_ctx_o;

  int errors = 0, checks = 0;
  bit done = 0;
  string phase = "R1";

  ctx_bank_switch #(.DATA_W(DW), .NUM_FIELDS(NF),
    .DEF_VALS({8'h55, 8'h44, 8'h33, 8'h22, 8'h11})) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_idx(wr_idx),
    .wr_data(wr_data), .ctx_sel(ctx_sel), .frame_start(frame_start),
    .readout_active(readout_active), .act_regs(act_regs),
    .integ_ctx_o(integ_ctx_o), .rest_ctx_o(rest_ctx_o));

  always #2.5 clk = ~clk;

  // behavioural reference: shadow tables and active values
  int ma[2][NF];
  int mact[NF];
  int mic, mrc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        ma[0][i] = 17 * (i + 1); ma[1][i] = 17 * (i + 1); mact[i] = 17 * (i + 1);
      end
      mic = 0; mrc = 0;
    end else begin
      if (frame_start && !readout_active) begin
        mact[0] = ma[ctx_sel][0];
        for (int i = 1; i < NF; i++) mact[i] = ma[mic][i];
        mrc = mic;
        mic = int'(ctx_sel);
      end
      if (wr_en && int'(wr_idx) < NF) ma[wr_ctx][wr_idx] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      for (int i = 0; i < NF; i++)
        if (int'(act_regs[i*DW +: DW]) != mact[i]) begin
          errors++;
          $display("FAIL %s model field %0d actual=%h expected=%h", phase, i, act_regs[i*DW +: DW], mact[i]);
        end
      if (int'(integ_ctx_o) != mic || int'(rest_ctx_o) != mrc) begin
        errors++;
        $display("FAIL %s model ctx actual=%0d/%0d expected=%0d/%0d", phase, integ_ctx_o, rest_ctx_o, mic, mrc);
      end
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic bound(); tick(); frame_start = 1; readout_active = 0; tick(); frame_start = 0; endtask
  task automatic readout(int n); readout_active = 1; repeat (n) tick(); readout_active = 0; endtask
  task automatic wr(bit c, int idx, int d);
    wr_en = 1; wr_ctx = c; wr_idx = IW'(idx); wr_data = DW'(d); tick(); wr_en = 0;
  endtask

  task automatic chk(string tag, int idx, int exp);
    checks++;
    if (int'(act_regs[idx*DW +: DW]) != exp) begin
      errors++;
      $display("FAIL %s field %0d actual=%h expected=%h", tag, idx, act_regs[idx*DW +: DW], exp);
    end
  endtask
  task automatic chk_ctx(string tag, int ei, int er);
    checks++;
    if (int'(integ_ctx_o) != ei || int'(rest_ctx_o) != er) begin
      errors++;
      $display("FAIL %s ctx actual=%0d/%0d expected=%0d/%0d", tag, integ_ctx_o, rest_ctx_o, ei, er);
    end
  endtask
  task automatic chk_all(string tag, int base0, int base_rest);
    chk(tag, 0, base0);
    for (int i = 1; i < NF; i++) chk(tag, i, base_rest + i);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset values and context A
    for (int i = 0; i < NF; i++) chk("R1", i, 17 * (i + 1));
    chk_ctx("R1", 0, 0);
    // R1 context B also holds defaults
    ctx_sel = 1; readout(4); bound(); readout(4); bound();
    for (int i = 0; i < NF; i++) chk("R1", i, 17 * (i + 1));
    chk_ctx("R1", 1, 1);
    ctx_sel = 0; bound(); bound();
    // R6 writes mid-readout to both sets, visible only at boundary
    phase = "R6";
    readout_active = 1;
    for (int i = 0; i < NF; i++) begin wr(0, i, 'hA0 + i); wr(1, i, 'hB0 + i); end
    chk("R6", 0, 17);
    readout_active = 0;
    bound();
    chk_all("R6", 'hA0, 'hA0);
    // R3 / R4 switch A to B
    phase = "R3";
    readout_active = 1; ctx_sel = 1; repeat (3) tick();
    chk_all("R2", 'hA0, 'hA0);
    bound();
    chk_all("R3", 'hB0, 'hA0);
    chk_ctx("R3", 1, 0);
    phase = "R4";
    readout(5); bound();
    chk_all("R4", 'hB0, 'hB0);
    chk_ctx("R4", 1, 1);
    // R5 switch B back to A
    phase = "R5";
    readout_active = 1; ctx_sel = 0; tick(); readout_active = 0;
    bound();
    chk_all("R5", 'hA0, 'hB0);
    chk_ctx("R5", 0, 1);
    readout(3); bound();
    chk_all("R5", 'hA0, 'hA0);
    // R9 select glitch between boundaries
    phase = "R9";
    readout_active = 1; ctx_sel = 1; tick(); tick(); ctx_sel = 0; tick(); readout_active = 0;
    bound();
    chk_all("R9", 'hA0, 'hA0);
    chk_ctx("R9", 0, 0);
    // R7 frame_start during readout ignored
    phase = "R7";
    wr(0, 1, 'h5A);
    readout_active = 1; ctx_sel = 1; frame_start = 1; tick(); frame_start = 0; tick();
    chk("R7", 1, 'hA1); chk("R7", 0, 'hA0);
    chk_ctx("R7", 0, 0);
    ctx_sel = 0; readout_active = 0;
    bound();
    chk("R7", 1, 'h5A);
    wr(0, 1, 'hA1); bound();
    // R8 out-of-range writes
    phase = "R8";
    for (int k = NF; k < 8; k++) begin wr(0, k, 'hEE); wr(1, k, 'hEE); end
    bound();
    chk_all("R8", 'hA0, 'hA0);
    ctx_sel = 1; bound(); bound();
    chk_all("R8", 'hB0, 'hB0);
    ctx_sel = 0; bound(); bound();
    // R6 write in the boundary cycle
    phase = "R6";
    tick(); frame_start = 1; wr_en = 1; wr_ctx = 0; wr_idx = 3'd2; wr_data = 8'h77;
    tick(); frame_start = 0; wr_en = 0;
    chk("R6", 2, 'hA2);
    bound();
    chk("R6", 2, 'h77);
    // R10 reversal at the completing boundary
    phase = "R10";
    wr(0, 2, 'hA2); bound();
    ctx_sel = 1; bound();
    chk_all("R10", 'hB0, 'hA0);
    ctx_sel = 0; bound();
    chk_all("R10", 'hA0, 'hB0);
    chk_ctx("R10", 0, 1);
    bound();
    chk_all("R10", 'hA0, 'hA0);
    chk_ctx("R10", 0, 0);
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule